// File: doc/BRIEF.md
# Redundant Output Pair Voter with Selectable Trip Polarity

This block merges the commands of two redundant output channels into a single field output vector. Each channel brings a command vector (one bit per output point) and a diagnostic fault report. A polarity setting, captured while the block is held in reset, selects one of two behaviours. In de-energize-to-trip operation an energized output is held only while every healthy channel asks for it. In energize-to-action operation the output energizes as soon as any healthy channel asks for it. In both polarities the safe value is 0.

A reported fault is latched per channel until an explicit synchronous clear. With one channel latched faulty, the block follows the other channel alone. With both channels latched faulty, it forces every point to the safe value and raises a fail-safe indicator.

Every pin is a plain level signal, sampled on each clock. Commands are not a transaction stream, so there is no valid/ready handshake and no back-pressure. A new command vector is taken on every rising edge.

Top module: `ovt_dual_voter`

## Requirements
- R1: `pol_cfg` is captured on every clock edge while `rst_n` is low. `mode_o` reports the captured value: 0 means de-energize-to-trip, 1 means energize-to-action.
- R2: Changes on `pol_cfg` while `rst_n` is high have no effect on `mode_o` or on the voting.
- R3: In de-energize-to-trip mode with no channel faulted, each point of `field_o` equals the AND of the two channel commands for that point.
- R4: In energize-to-action mode with no channel faulted, each point of `field_o` equals the OR of the two channel commands for that point.
- R5: In either mode, when exactly one channel is faulted, `field_o` equals the command of the other channel.
- R6: When both channels are faulted, every bit of `field_o` is 0 and `failsafe_o` is 1. Otherwise `failsafe_o` is 0.
- R7: A fault report (`fault_in[0]` for channel A, `fault_in[1]` for channel B) latches that channel's fault until `fault_clr` is high at a clock edge. A fault reported in the same cycle as the clear stays latched.
- R8: `vote_state` shows the latched faults as {B, A}: 00 dual vote, 01 B alone, 10 A alone, 11 fail-safe.
- R9: After reset, `field_o` is 0, `vote_state` is 00 and `failsafe_o` is 0.
- R10: Outputs are registered. Each edge applies the commands, fault reports and clear present before that edge, so a fault reported in a cycle already governs the output produced at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; polarity is captured while low |
| pol_cfg | input | 1 | Trip polarity setting: 0 de-energize-to-trip, 1 energize-to-action |
| cmd_a | input | N_PTS | Channel A command, one bit per point |
| cmd_b | input | N_PTS | Channel B command, one bit per point |
| fault_in | input | 2 | Fault reports; bit 0 channel A, bit 1 channel B |
| fault_clr | input | 1 | Synchronous clear of latched faults |
| field_o | output | N_PTS | Voted field output |
| mode_o | output | 1 | Captured polarity |
| vote_state | output | 2 | Latched faults {B, A} |
| failsafe_o | output | 1 | Both channels faulted |

## Verification
The bench builds the block with N_PTS = 4. With that width, one command pair such as 1100/1010 puts all four per-point command combinations into a single vector. Sweeping all 16×16 command pairs under each of the four fault patterns in both polarities covers every voting case exhaustively. The bench holds `pol_cfg` at the opposite value throughout operation, so every compare also exercises the rule that the setting is ignored once the block leaves reset.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  typedef enum logic {
    TRIP_DEENERGIZE = 1'b0,
    TRIP_ENERGIZE   = 1'b1
  } trip_pol_e;

  localparam int unsigned CH_COUNT = 2;
endpackage

// File: rtl/ovt_mode_capture.sv
module ovt_mode_capture
  import ovt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pol_cfg,
  output trip_pol_e pol_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= trip_pol_e'(pol_cfg);
  end

  // polarity frozen once out of reset
  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(pol_q));
endmodule

// File: rtl/ovt_fault_latch.sv
module ovt_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_clr,
  input  logic fault_rpt,
  output logic fault_nxt,
  output logic fault_q
);
  // a report in the clearing cycle wins: faults are never lost
  always_comb fault_nxt = fault_rpt | (fault_q & ~fault_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_nxt;
  end

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);
  assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_rpt |=> fault_q);
endmodule

// File: rtl/ovt_point_vote.sv
module ovt_point_vote
  import ovt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  trip_pol_e           pol,
  input  logic [CH_COUNT-1:0] healthy,
  input  logic [CH_COUNT-1:0] cmd,
  output logic                out_q
);
  logic any_on, all_on, vote;

  always_comb begin
    any_on = |(cmd & healthy);
    all_on = &(cmd | ~healthy) & (|healthy);
    vote   = (pol == TRIP_ENERGIZE) ? any_on : all_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= vote;
  end

  assert_no_healthy_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (healthy == '0) |=> !out_q);
endmodule

// File: rtl/ovt_dual_voter.sv
module ovt_dual_voter
  import ovt_pkg::*;
#(
  parameter int unsigned N_PTS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pol_cfg,
  input  logic [N_PTS-1:0]    cmd_a,
  input  logic [N_PTS-1:0]    cmd_b,
  input  logic [CH_COUNT-1:0] fault_in,
  input  logic                fault_clr,
  output logic [N_PTS-1:0]    field_o,
  output logic                mode_o,
  output logic [CH_COUNT-1:0] vote_state,
  output logic                failsafe_o
);
  trip_pol_e           pol_q;
  logic [CH_COUNT-1:0] flt_nxt;
  logic [CH_COUNT-1:0] flt_q;

  ovt_mode_capture u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .pol_cfg (pol_cfg),
    .pol_q   (pol_q)
  );

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    ovt_fault_latch u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_clr (fault_clr),
      .fault_rpt (fault_in[c]),
      .fault_nxt (flt_nxt[c]),
      .fault_q   (flt_q[c])
    );
  end

  for (genvar p = 0; p < N_PTS; p++) begin : g_pt
    ovt_point_vote u_vote (
      .clk     (clk),
      .rst_n   (rst_n),
      .pol     (pol_q),
      .healthy (~flt_nxt),
      .cmd     ({cmd_b[p], cmd_a[p]}),
      .out_q   (field_o[p])
    );
  end

  assign mode_o     = pol_q;
  assign vote_state = flt_q;
  assign failsafe_o = &flt_q;

  assert_failsafe_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe_o |-> (field_o == '0));
  assert_follow_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q == 2'b01) && $past(rst_n) |-> (field_o == $past(cmd_b)));
  assert_follow_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q == 2'b10) && $past(rst_n) |-> (field_o == $past(cmd_a)));
  assert_dual_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q == 2'b00) && (pol_q == TRIP_DEENERGIZE) && $past(rst_n)
      |-> (field_o == ($past(cmd_a) & $past(cmd_b))));
  assert_dual_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q == 2'b00) && (pol_q == TRIP_ENERGIZE) && $past(rst_n)
      |-> (field_o == ($past(cmd_a) | $past(cmd_b))));
endmodule

// File: tb/ovt_dual_voter_tb.sv
module ovt_dual_voter_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pol_cfg = 1'b0;
  logic [N-1:0] cmd_a = '0, cmd_b = '0;
  logic [1:0]   fault_in = '0;
  logic         fault_clr = 1'b0;
  logic [N-1:0] field_o;
  logic         mode_o;
  logic [1:0]   vote_state;
  logic         failsafe_o;

  int checks = 0, fails = 0;
  int m_pol = 0;
  int m_flt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovt_dual_voter #(.N_PTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pol_cfg(pol_cfg), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .fault_in(fault_in), .fault_clr(fault_clr), .field_o(field_o),
    .mode_o(mode_o), .vote_state(vote_state), .failsafe_o(failsafe_o));

  function automatic int exp_out(int pol, int f, int a, int b);
    int r = 0;
    for (int p = 0; p < N; p++) begin
      int ab = (a >> p) & 1;
      int bb = (b >> p) & 1;
      int ha = ((f & 1) == 0) ? 1 : 0;
      int hb = ((f & 2) == 0) ? 1 : 0;
      int v;
      if (ha == 0 && hb == 0)      v = 0;
      else if (ha == 0)            v = bb;
      else if (hb == 0)            v = ab;
      else if (pol == 1)           v = ab | bb;
      else                         v = ab & bb;
      r |= v << p;
    end
    return r;
  endfunction

  task automatic compare(string tag, int e_out, int e_st, int e_fs, int e_mode);
    checks++;
    if (int'(field_o) != e_out || int'(vote_state) != e_st ||
        int'(failsafe_o) != e_fs || int'(mode_o) != e_mode) begin
      fails++;
      $display("FAIL %s: out=%b st=%b fs=%b mode=%b expected out=%0h st=%0d fs=%0d mode=%0d",
               tag, field_o, vote_state, failsafe_o, mode_o, e_out, e_st, e_fs, e_mode);
    end
  endtask

  task automatic do_reset(int pol);
    @(negedge clk);
    rst_n = 1'b0; pol_cfg = pol[0]; fault_in = '0; fault_clr = 1'b0;
    cmd_a = '1; cmd_b = '1;
    repeat (3) @(posedge clk);
    m_pol = pol; m_flt = 0;
    #1;
    compare("R9", 0, 0, 0, m_pol);
    @(negedge clk);
    rst_n = 1'b1;
    pol_cfg = ~pol[0];  // R2: setting flipped during operation
    #1;
    compare("R1", 0, 0, 0, m_pol);
  endtask

  // one clock: drive, let edge pass, update model, compare
  task automatic step(int f, int clr, int a, int b, string tag);
    int e;
    @(negedge clk);
    fault_in = f[1:0]; fault_clr = clr[0]; cmd_a = a[N-1:0]; cmd_b = b[N-1:0];
    @(posedge clk);
    m_flt = clr ? f : (m_flt | f);
    e = exp_out(m_pol, m_flt, a, b);
    #1;
    compare(tag, e, m_flt, (m_flt == 3) ? 1 : 0, m_pol);
  endtask

  function automatic string vote_tag(int pol, int f);
    if (f == 3) return "R6";
    if (f != 0) return "R5";
    return (pol == 1) ? "R4" : "R3";
  endfunction

  initial begin
    for (int pol = 0; pol < 2; pol++) begin
      do_reset(pol);
      // R10: fault reported in a cycle governs that cycle's output
      step(1, 0, 4'b1100, 4'b1010, "R10");
      step(0, 0, 4'b0110, 4'b0011, "R7");
      // R7: clear together with a new report keeps the new report
      step(2, 1, 4'b1100, 4'b1010, "R7");
      step(0, 0, 4'b1111, 4'b0000, "R8");
      step(0, 1, 4'b1100, 4'b1010, "R7");
      step(0, 0, 4'b1100, 4'b1010, pol ? "R4" : "R3");
      // exhaustive sweep of faults x commands
      for (int f = 0; f < 4; f++) begin
        step(f, 1, 0, 0, "R8");
        for (int a = 0; a < (1 << N); a++)
          for (int b = 0; b < (1 << N); b++)
            step(0, 0, a, b, vote_tag(pol, f));
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule